// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a bank of 32-bit configuration registers on a simple single-cycle bus. One slot holds a key register. A run of registers directly above it stays write-protected until software writes a fixed magic word to the key. The key slot does not keep the word that was written. It keeps one lock bit, and that bit reads back as 1 only after the magic word arrives. Any other word clears the bit. Software normally locks the bank again by writing the bitwise complement of the magic word, then polls until the key reads zero.

Writes that the lock refuses are dropped without side effects on the target register. Each one sets a sticky error flag and adds one to a saturating counter. Both live in a status register that is never protected. One protected register also has read-only bits. A two-bit revision input selects which bits are read-only, and two of the revision codes share one mask. Reads are never gated by the lock, and the read data and ready signal are registered.

Top module: `keyed_cfg_bank`

## Requirements
- R1: After reset the lock bit is 0 and the key register (word 1) reads 0. The status register (word 0) reads 0, register 4 reads its reset value RO_RST, and every other mapped register reads 0.
- R2: A write to word 1 whose full data word equals MAGIC sets the lock bit, and word 1 then reads 1. Byte strobes do not take part in the comparison.
- R3: A write to word 1 with any other value, including the complement of MAGIC, clears the lock bit. Word 1 then reads 0, and bits 31:1 of word 1 always read 0.
- R4: A write to word 1 is acted on whatever the current lock state is.
- R5: While the lock bit is 0, a write to a word strictly between 1 and WIN_END (words 2 to 11 by default) leaves every stored register unchanged. While the lock bit is 1, such a write takes effect.
- R6: Words WIN_END and above, up to NUM_REGS-1, accept writes whatever the lock state is.
- R7: A write updates only the bytes whose strobe bit is set; strobe bit k covers data bits 8k+7:8k.
- R8: A write to register 4 keeps the old value of the read-only bits. These bits are RO_MASK_A for revision code 0, RO_MASK_B for codes 1 and 2, and RO_MASK_A|RO_MASK_B for code 3.
- R9: Each write refused by the lock sets status bit 0 (sticky) and increments the counter in status bits 15:8. The counter saturates at 255.
- R10: A write to word 0 with strobe bit 0 set clears the flag when data bit 0 is 1, and clears the counter when data bit 1 is 1. This works while the bank is locked.
- R11: Reads are never blocked by the lock. Reads of words NUM_REGS and above return 0, and writes to those words change nothing and are not counted as refused.
- R12: The ready output is 1 exactly in the cycle after a request. The read data for a read request appears in that same cycle, and the read data is 0 after a write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request, one transfer per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (6) | Word address |
| be | input | DATA_W/8 (4) | Byte strobes for writes |
| wdata | input | DATA_W (32) | Write data |
| rev | input | 2 | Silicon revision code selecting the read-only mask |
| rdata | output | DATA_W (32) | Registered read data |
| ready | output | 1 | Transfer completes (one cycle after req) |

## Verification
The bench builds the bank with its default parameters: 16 words with the key in word 1, the protected run ending at word 12, and a 6-bit address. With a 6-bit address, words 16 to 63 are unmapped, so the bench can reach them. The 8-bit counter saturates after 255 refusals, which is short enough for a directed test to drive it to its limit. The default masks for revisions 0 and 1/2 do not overlap, so one write pattern shows which mask was applied for each of the four revision codes.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  typedef enum logic [1:0] {
    REV_BASE = 2'd0,
    REV_B1   = 2'd1,
    REV_B2   = 2'd2,
    REV_RSVD = 2'd3
  } rev_e;

  localparam int STAT_CNT_LSB = 8;

endpackage

// File: rtl/cfg_key_lock.sv
module cfg_key_lock #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] MAGIC  = 32'h1688_A8A8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              lock_q
);
  // Only the comparison result is kept; the written word is discarded.
  always_ff @(posedge clk) begin
    if (rst)         lock_q <= 1'b0;
    else if (key_wr) lock_q <= (key_data == MAGIC);
  end
endmodule

// File: rtl/cfg_refuse_log.sv
module cfg_refuse_log #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refuse,
  input  logic             clr_flag,
  input  logic             clr_cnt,
  output logic             flag_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (refuse)        flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      if (refuse) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (clr_cnt) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array
  import keyed_cfg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 6,
  parameter int                NUM_REGS  = 16,
  parameter int                STAT_IDX  = 0,
  parameter int                KEY_IDX   = 1,
  parameter int                RO_IDX    = 4,
  parameter logic [DATA_W-1:0] RO_RST    = 32'h5A3C_C3A5,
  parameter logic [DATA_W-1:0] RO_MASK_A = 32'hFF00_0000,
  parameter logic [DATA_W-1:0] RO_MASK_B = 32'h00FF_00F0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_idx,
  input  logic [DATA_W/8-1:0]        wr_be,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [1:0]                 rev,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] be_mask;
  logic [DATA_W-1:0] ro_mask;

  always_comb begin
    for (int b = 0; b < BE_W; b++) be_mask[8*b +: 8] = {8{wr_be[b]}};
  end

  always_comb begin
    case (rev_e'(rev))
      REV_BASE:       ro_mask = RO_MASK_A;
      REV_B1, REV_B2: ro_mask = RO_MASK_B;
      default:        ro_mask = RO_MASK_A | RO_MASK_B;
    endcase
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    if (i == STAT_IDX || i == KEY_IDX) begin : g_hole
      assign regs_flat[i*DATA_W +: DATA_W] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] merged;
      logic              hit;
      assign hit = wr_en && (wr_idx == ADDR_W'(i));
      if (i == RO_IDX) begin : g_ro
        always_comb begin
          merged = (q & ~be_mask) | (wr_data & be_mask);
          merged = (merged & ~ro_mask) | (q & ro_mask);
        end
        always_ff @(posedge clk) begin
          if (rst)      q <= RO_RST;
          else if (hit) q <= merged;
        end
      end else begin : g_rw
        assign merged = (q & ~be_mask) | (wr_data & be_mask);
        always_ff @(posedge clk) begin
          if (rst)      q <= '0;
          else if (hit) q <= merged;
        end
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
    end
  end
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import keyed_cfg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 6,
  parameter int                NUM_REGS  = 16,
  parameter int                STAT_IDX  = 0,
  parameter int                KEY_IDX   = 1,
  parameter int                WIN_END   = 12,
  parameter int                RO_IDX    = 4,
  parameter int                CNT_W     = 8,
  parameter logic [DATA_W-1:0] MAGIC     = 32'h1688_A8A8,
  parameter logic [DATA_W-1:0] RO_RST    = 32'h5A3C_C3A5,
  parameter logic [DATA_W-1:0] RO_MASK_A = 32'hFF00_0000,
  parameter logic [DATA_W-1:0] RO_MASK_B = 32'h00FF_00F0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [1:0]          rev,
  output logic [DATA_W-1:0]   rdata,
  output logic                ready
);
  localparam int              IDX_W  = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);
  localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_IDX);
  localparam logic [ADDR_W:0]   WIN_A  = (ADDR_W+1)'(WIN_END);
  localparam logic [ADDR_W:0]   NUM_A  = (ADDR_W+1)'(NUM_REGS);

  logic                       wr_cyc, hit_key, hit_stat, mapped, in_win;
  logic                       lock_q, refuse, store_wr, clr_flag, clr_cnt;
  logic                       err_flag;
  logic [CNT_W-1:0]           err_cnt;
  logic [NUM_REGS*DATA_W-1:0] store_flat;
  logic [IDX_W-1:0]           idx;
  logic [DATA_W-1:0]          rd_next;

  assign wr_cyc   = req && we;
  assign hit_key  = (addr == KEY_A);
  assign hit_stat = (addr == STAT_A);
  assign mapped   = ({1'b0, addr} < NUM_A);
  assign in_win   = (addr > KEY_A) && ({1'b0, addr} < WIN_A);
  assign idx      = addr[IDX_W-1:0];

  assign refuse   = wr_cyc && in_win && !lock_q;
  assign store_wr = wr_cyc && mapped && !hit_key && !hit_stat && !(in_win && !lock_q);
  assign clr_flag = wr_cyc && hit_stat && be[0] && wdata[0];
  assign clr_cnt  = wr_cyc && hit_stat && be[0] && wdata[1];

  cfg_key_lock #(.DATA_W(DATA_W), .MAGIC(MAGIC)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_cyc && hit_key),
    .key_data (wdata),
    .lock_q   (lock_q)
  );

  cfg_refuse_log #(.CNT_W(CNT_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .refuse   (refuse),
    .clr_flag (clr_flag),
    .clr_cnt  (clr_cnt),
    .flag_q   (err_flag),
    .cnt_q    (err_cnt)
  );

  cfg_reg_array #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .STAT_IDX(STAT_IDX), .KEY_IDX(KEY_IDX), .RO_IDX(RO_IDX),
    .RO_RST(RO_RST), .RO_MASK_A(RO_MASK_A), .RO_MASK_B(RO_MASK_B)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (store_wr),
    .wr_idx    (addr),
    .wr_be     (be),
    .wr_data   (wdata),
    .rev       (rev),
    .regs_flat (store_flat)
  );

  always_comb begin
    rd_next = '0;
    if (hit_stat) begin
      rd_next[0] = err_flag;
      rd_next[STAT_CNT_LSB +: CNT_W] = err_cnt;
    end else if (hit_key) begin
      rd_next[0] = lock_q;
    end else if (mapped) begin
      rd_next = store_flat[idx*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= req;
      rdata <= (req && !we) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/keyed_cfg_bank_chk.sv
module keyed_cfg_bank_chk #(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 6,
  parameter int                NUM_REGS = 16,
  parameter int                KEY_IDX  = 1,
  parameter int                WIN_END  = 12,
  parameter int                CNT_W    = 8,
  parameter logic [DATA_W-1:0] MAGIC    = 32'h1688_A8A8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req,
  input logic                       we,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wdata,
  input logic [DATA_W-1:0]          rdata,
  input logic                       ready,
  input logic                       lock_q,
  input logic [NUM_REGS*DATA_W-1:0] store_flat,
  input logic                       err_flag,
  input logic [CNT_W-1:0]           err_cnt
);
  localparam logic [ADDR_W:0] KEY_W = (ADDR_W+1)'(KEY_IDX);
  localparam logic [ADDR_W:0] END_W = (ADDR_W+1)'(WIN_END);
  localparam logic [ADDR_W:0] NUM_W = (ADDR_W+1)'(NUM_REGS);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [ADDR_W:0] a_ext;
  logic            win_wr_locked;
  assign a_ext         = {1'b0, addr};
  assign win_wr_locked = req && we && !lock_q && (a_ext > KEY_W) && (a_ext < END_W);

  AST_KEY_SETS_LOCK: assert property (@(posedge clk) disable iff (rst)
    req && we && (a_ext == KEY_W) |=> lock_q == ($past(wdata) == MAGIC)); // R4

  AST_KEY_READ_BIT: assert property (@(posedge clk) disable iff (rst)
    req && !we && (a_ext == KEY_W) |=> rdata[DATA_W-1:1] == '0); // R3

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    win_wr_locked |=> $stable(store_flat)); // R5

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    win_wr_locked |=> err_flag); // R9

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    win_wr_locked && (err_cnt == CMAX) |=> err_cnt == CMAX); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    req && !we && (a_ext >= NUM_W) |=> rdata == '0); // R11

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> ready); // R12

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ready); // R12
endmodule

bind keyed_cfg_bank keyed_cfg_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .KEY_IDX(KEY_IDX),
  .WIN_END(WIN_END), .CNT_W(CNT_W), .MAGIC(MAGIC)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ready(ready), .lock_q(lock_q), .store_flat(store_flat),
  .err_flag(err_flag), .err_cnt(err_cnt)
);

// File: tb/keyed_cfg_bank_tb.sv
module keyed_cfg_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAGIC  = 32'h1688_A8A8;
  localparam logic [31:0] RO_RST = 32'h5A3C_C3A5;
  localparam logic [31:0] MASK_A = 32'hFF00_0000;
  localparam logic [31:0] MASK_B = 32'h00FF_00F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [1:0] rev = '0;
  logic [31:0] rdata;
  logic ready;

  int checks = 0, errors = 0;

  logic [31:0] m_regs [16];
  logic        m_lock, m_flag;
  logic [7:0]  m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_bank u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rev(rev), .rdata(rdata), .ready(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ro_of(input logic [1:0] r);
    if (r == 2'd0) return MASK_A;
    if (r == 2'd3) return MASK_A | MASK_B;
    return MASK_B;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a == 6'd0) return {16'd0, m_cnt, 7'd0, m_flag};
    if (a == 6'd1) return {31'd0, m_lock};
    if (a < 6'd16) return m_regs[a[3:0]];
    return 32'd0;
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [3:0] b,
                             input logic [31:0] d, input logic [1:0] r);
    logic [31:0] bm, nv, ro;
    bm = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    if (a == 6'd1) m_lock = (d == MAGIC);
    else if (a == 6'd0) begin
      if (b[0] && d[0]) m_flag = 1'b0;
      if (b[0] && d[1]) m_cnt = 8'd0;
    end else if (a < 6'd16) begin
      if (a < 6'd12 && !m_lock) begin
        m_flag = 1'b1;
        if (m_cnt != 8'hFF) m_cnt = m_cnt + 8'd1;
      end else begin
        nv = (m_regs[a[3:0]] & ~bm) | (d & bm);
        if (a == 6'd4) begin
          ro = ro_of(r);
          nv = (nv & ~ro) | (m_regs[4] & ro);
        end
        m_regs[a[3:0]] = nv;
      end
    end
  endtask

  task automatic bus(input logic w, input logic [5:0] a, input logic [3:0] b,
                     input logic [31:0] d, input logic [1:0] r, output logic [31:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d; rev = r;
    @(posedge clk); #1;
    rd = rdata;
    chk("R12 ready after request", {31'd0, ready}, 32'd1);
    if (w) begin
      chk("R12 rdata zero after write", rd, 32'd0);
      model_write(a, b, d, r);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d, input logic [1:0] r);
    logic [31:0] x;
    bus(1'b1, a, b, d, r, x);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] x;
    bus(1'b0, a, 4'h0, 32'd0, 2'd0, x);
    chk(tag, x, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) m_regs[i] = (i == 4) ? RO_RST : 32'd0;
    m_lock = 1'b0; m_flag = 1'b0; m_cnt = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    rd_chk("R1 key after reset", 6'd1, 32'd0);
    rd_chk("R1 status after reset", 6'd0, 32'd0);
    rd_chk("R1 ro register reset value", 6'd4, RO_RST);
    rd_chk("R1 plain register reset", 6'd13, 32'd0);

    // R5, R9: locked write refused
    wr(6'd5, 4'hF, 32'hDEAD_BEEF, 2'd0);
    rd_chk("R5 locked write discarded", 6'd5, 32'd0);
    rd_chk("R9 flag and count after refusal", 6'd0, 32'h0000_0101);

    // R6: outside window writable while locked
    wr(6'd13, 4'hF, 32'hCAFE_0013, 2'd0);
    rd_chk("R6 outside window write while locked", 6'd13, 32'hCAFE_0013);

    // R2, R4: magic accepted while locked
    wr(6'd1, 4'h0, MAGIC, 2'd0);
    rd_chk("R2 R4 key reads one after magic", 6'd1, 32'd1);

    // R5 unlocked, R7 strobes
    wr(6'd5, 4'hF, 32'h1111_2222, 2'd0);
    rd_chk("R5 unlocked write taken", 6'd5, 32'h1111_2222);
    wr(6'd5, 4'b0101, 32'hAAAA_BBBB, 2'd0);
    rd_chk("R7 partial strobes", 6'd5, 32'h11AA_22BB);

    // R8: read-only bits per revision
    for (int r = 0; r < 4; r++) begin
      wr(6'd4, 4'hF, 32'hFFFF_FFFF, 2'(r));
      rd_chk($sformatf("R8 ro bits kept set rev %0d", r), 6'd4, m_regs[4]);
      wr(6'd4, 4'hF, 32'h0000_0000, 2'(r));
      rd_chk($sformatf("R8 ro bits kept clear rev %0d", r), 6'd4, m_regs[4]);
    end

    // R3: inverse locks; other values clear too
    wr(6'd1, 4'hF, ~MAGIC, 2'd0);
    rd_chk("R3 key reads zero after inverse", 6'd1, 32'd0);
    wr(6'd6, 4'hF, 32'h0000_0066, 2'd0);
    rd_chk("R3 R5 relocked write discarded", 6'd6, 32'd0);
    wr(6'd1, 4'hF, MAGIC, 2'd0);
    wr(6'd1, 4'hF, 32'h1234_5678, 2'd0);
    rd_chk("R3 arbitrary value clears lock", 6'd1, 32'd0);

    // R11: unmapped
    wr(6'd40, 4'hF, 32'hFFFF_FFFF, 2'd0);
    rd_chk("R11 unmapped read zero", 6'd40, 32'd0);
    rd_chk("R11 unmapped write not counted", 6'd0, {16'd0, m_cnt, 7'd0, m_flag});

    // R9 saturation, R10 clearing while locked
    for (int i = 0; i < 260; i++) wr(6'd7, 4'hF, 32'(i), 2'd0);
    rd_chk("R9 counter saturates", 6'd0, 32'h0000_FF01);
    wr(6'd0, 4'h1, 32'h0000_0002, 2'd0);
    rd_chk("R10 count cleared flag kept", 6'd0, 32'h0000_0001);
    wr(6'd0, 4'h1, 32'h0000_0001, 2'd0);
    rd_chk("R10 flag cleared", 6'd0, 32'h0000_0000);

    // R12: ready drops when idle
    @(posedge clk); #1;
    chk("R12 ready low when idle", {31'd0, ready}, 32'd0);

    // Random mix checked against the model (R2 R3 R5 R6 R7 R8 R9 R10 R11)
    for (int n = 0; n < 600; n++) begin
      logic [5:0]  a;
      logic [31:0] d;
      int          sel;
      a = 6'($urandom_range(0, 19));
      sel = $urandom_range(0, 3);
      d = (sel == 0) ? MAGIC : (sel == 1) ? ~MAGIC : $urandom;
      if ($urandom_range(0, 1) == 1)
        wr(a, 4'($urandom_range(0, 15)), d, 2'($urandom_range(0, 3)));
      else begin
        bus(1'b0, a, 4'h0, 32'd0, 2'd0, x);
        chk("R11 random read vs model", x, model_read(a));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule